// File: doc/BRIEF.md
# Event Counter Bank with Sticky Status

This block holds four 16-bit event counters and one 8-bit sticky status word behind a small register port. Each counter advances by one on every clock cycle in which its event input is high. Each status bit is set by a one-cycle pulse on its own status input and stays set until software clears it.

Two global mode inputs set the policy. The counter mode input selects between two behaviours. In wrapping mode the counters are read-only and pass from 0xFFFF back to zero. In saturating mode a counter stops at 0xFFFF, and a read of that counter also clears it. The status mode input selects how status bits are cleared. In one mode software writes a 1 to a bit to clear it. In the other mode a read of the status word clears the bits that the read returned.

Reads go through a two-state access sequencer. In `ACC_IDLE` no data is valid. A read strobe captures the addressed word and moves the sequencer to `ACC_RESPOND`, where `rd_valid` is high for that cycle. The sequencer then goes back to `ACC_IDLE`. If a new read strobe arrives while it is in `ACC_RESPOND`, it stays in `ACC_RESPOND` for another cycle. Addresses 0 to 3 select the counters, address 4 selects the status word, and addresses 5 to 7 read as zero.

Top module: `ecb_top`

## Requirements
- R1: After reset every counter and every status bit is zero, and `rd_valid` is low.
- R2: With `sat_mode`=0 (wrapping, the reset default), each cycle with `cnt_evt[k]` high adds one to counter k, and a counter at 0xFFFF goes to 0x0000 on the next event.
- R3: With `sat_mode`=1, a counter at 0xFFFF stays at 0xFFFF for any further events.
- R4: A read strobe at address k (0..3) returns counter k on `rdata` in the next cycle, with `rd_valid` high for exactly that cycle. With `sat_mode`=1 the read also clears the counter to zero.
- R5: With `sat_mode`=0, reading a counter leaves its value unchanged.
- R6: Writes to addresses 0..3 have no effect on any counter, in either mode.
- R7: With `sat_mode`=1, if an event and a read of the same counter fall in the same cycle, the read returns the value from before that event and the counter becomes 1.
- R8: A pulse on `stat_evt[i]` sets status bit i, and the bit stays set until it is cleared. A read at address 4 returns the status bits in `rdata[7:0]`, with `rdata[15:8]` zero.
- R9: With `clr_on_rd`=0, a write at address 4 clears every status bit whose `wdata` bit is 1 and leaves the other bits unchanged. In this mode, reads do not clear status bits.
- R10: With `clr_on_rd`=1, a read at address 4 clears the status bits it returned. In this mode, writes to address 4 have no effect.
- R11: If a status event and a clear of the same bit fall in the same cycle, the bit stays set.
- R12: Reads at addresses 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_mode | input | 1 | 0 = wrapping read-only counters, 1 = saturating counters cleared by a read |
| clr_on_rd | input | 1 | 0 = write 1 to clear status, 1 = read clears status |
| cnt_evt | input | 4 | Event pulse per counter |
| stat_evt | input | 8 | Set pulse per status bit |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The bench drives counters across the 0xFFFF boundary in both modes. A design that saturates while in wrapping mode, or wraps while in saturating mode, returns 0xFFFF where 0 is expected, or the reverse. It also puts an event in the same cycle as a clearing read, for both a counter and a status bit. If the counter clears after the increment, the follow-up read returns 0 instead of 1. If a status clear wins over the event, the bit is lost. Writes to counter addresses and repeated reads in the non-clearing modes are followed by read-backs, so any stray clear or load shows up as a wrong value.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
    typedef enum logic {
        ACC_IDLE    = 1'b0,
        ACC_RESPOND = 1'b1
    } acc_state_t;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sat_mode,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            // the read has already captured the old value; a same-cycle event restarts at one
            cnt <= evt ? CNT_ONE : '0;
        end else if (evt) begin
            if (!(sat_mode && cnt == CNT_MAX)) begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/ecb_status.sv
module ecb_status #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_on_rd,
    input  logic [STAT_W-1:0] evt,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wmask,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] clr_mask;

    always_comb begin
        if (clr_on_rd) begin
            clr_mask = rd_hit ? stat : '0;
        end else begin
            clr_mask = wr_hit ? wmask : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            // a set in the same cycle takes priority over a clear
            stat <= (stat & ~clr_mask) | evt;
        end
    end
endmodule

// File: rtl/ecb_access.sv
module ecb_access
    import ecb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:    state_d = rd_en ? ACC_RESPOND : ACC_IDLE;
            ACC_RESPOND: state_d = rd_en ? ACC_RESPOND : ACC_IDLE;
            default:     state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

    assign rd_valid = (state_q == ACC_RESPOND);
endmodule

// File: rtl/ecb_top.sv
module ecb_top #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sat_mode,
    input  logic              clr_on_rd,
    input  logic [NUM_CNT-1:0] cnt_evt,
    input  logic [STAT_W-1:0] stat_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CNT);

    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [NUM_CNT-1:0]       cnt_sel;
    logic [STAT_W-1:0]        stat_q;
    logic [DATA_W-1:0]        rd_word;
    logic                     stat_rd_hit;
    logic                     stat_wr_hit;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        logic clr;
        assign cnt_sel[g] = (addr == MY_ADDR);
        assign clr        = sat_mode && rd_en && cnt_sel[g];
        ecb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sat_mode (sat_mode),
            .evt      (cnt_evt[g]),
            .clr      (clr),
            .cnt      (cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    assign stat_rd_hit = rd_en && (addr == STAT_ADDR);
    assign stat_wr_hit = wr_en && (addr == STAT_ADDR);

    ecb_status #(.STAT_W(STAT_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_on_rd (clr_on_rd),
        .evt       (stat_evt),
        .rd_hit    (stat_rd_hit),
        .wr_hit    (stat_wr_hit),
        .wmask     (wdata[STAT_W-1:0]),
        .stat      (stat_q)
    );

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (cnt_sel[k]) rd_word = DATA_W'(cnt_flat[k*CNT_W +: CNT_W]);
        end
        if (addr == STAT_ADDR) rd_word = DATA_W'(stat_q);
    end

    ecb_access #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_word  (rd_word),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 8,
    parameter int ADDR_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sat_mode,
    input logic [NUM_CNT-1:0]       cnt_evt,
    input logic [STAT_W-1:0]        stat_evt,
    input logic [ADDR_W-1:0]        addr,
    input logic                     rd_en,
    input logic                     wr_en,
    input logic                     rd_valid,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [STAT_W-1:0]        stat_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_mode && cnt_evt[0] && cnt_flat[CNT_W-1:0] == CNT_MAX)
        |=> (cnt_flat[CNT_W-1:0] == '0));

    // R3
    a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_mode && cnt_flat[CNT_W-1:0] == CNT_MAX && !(rd_en && addr == '0))
        |=> (cnt_flat[CNT_W-1:0] == CNT_MAX));

    // R4
    a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R6
    a_r6_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && cnt_evt == '0) |=> $stable(cnt_flat));

    // R8
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R11
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stat_evt[0] |=> stat_q[0]);
endmodule

bind ecb_top ecb_checker #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .STAT_W(STAT_W), .ADDR_W(ADDR_W)
) u_ecb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sat_mode (sat_mode),
    .cnt_evt  (cnt_evt),
    .stat_evt (stat_evt),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rd_valid (rd_valid),
    .cnt_flat (cnt_flat),
    .stat_q   (stat_q)
);

// File: tb/test_ecb_top.sv
module test_ecb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sat_mode = 1'b0;
    logic        clr_on_rd = 1'b0;
    logic [3:0]  cnt_evt = '0;
    logic [7:0]  stat_evt = '0;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    ecb_top i_ecb_top (
        .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .clr_on_rd(clr_on_rd),
        .cnt_evt(cnt_evt), .stat_evt(stat_evt), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
    );

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4: rd_valid without pending read, rdata=%h expected none", rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
                end
            end
        end
    end

    // one-cycle access with optional same-cycle events
    task automatic access(input logic rd, input logic wr, input logic [2:0] a,
                          input logic [15:0] wd, input logic [3:0] ce,
                          input logic [7:0] se, input logic [15:0] e, input string t);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = wd; cnt_evt = ce; stat_evt = se;
        if (rd) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(negedge clk);
        rd_en = 0; wr_en = 0; cnt_evt = '0; stat_evt = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        access(1'b1, 1'b0, a, 16'h0, 4'h0, 8'h0, e, t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        access(1'b0, 1'b1, a, d, 4'h0, 8'h0, 16'h0, "");
    endtask

    task automatic pulse_cnt(input logic [3:0] m, input int n);
        @(negedge clk);
        cnt_evt = m;
        repeat (n) @(negedge clk);
        cnt_evt = '0;
    endtask

    task automatic pulse_stat(input logic [7:0] m);
        @(negedge clk);
        stat_evt = m;
        @(negedge clk);
        stat_evt = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_valid=%b expected 0", rd_valid);
        end
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 5; a++) rd(3'(a), 16'h0, "R1");
        // R12 unmapped
        rd(3'd5, 16'h0, "R12");
        rd(3'd6, 16'h0, "R12");
        rd(3'd7, 16'h0, "R12");

        // R2 counting in wrapping mode
        pulse_cnt(4'b0101, 3);
        pulse_cnt(4'b0100, 2);
        rd(3'd0, 16'd3, "R2");
        rd(3'd0, 16'd3, "R5");
        rd(3'd2, 16'd5, "R2");
        // R6 write ignored in wrapping mode
        wr(3'd0, 16'h1234);
        rd(3'd0, 16'd3, "R6");

        // saturating mode
        sat_mode = 1'b1;
        wr(3'd2, 16'hBEEF);
        rd(3'd2, 16'd5, "R6");
        rd(3'd0, 16'd3, "R4");
        rd(3'd0, 16'd0, "R4");
        // R7 same-cycle event and clearing read
        pulse_cnt(4'b1000, 2);
        access(1'b1, 1'b0, 3'd3, 16'h0, 4'b1000, 8'h0, 16'd2, "R7");
        rd(3'd3, 16'd1, "R7");
        // R3 saturation at max
        pulse_cnt(4'b0010, 65536);
        rd(3'd1, 16'hFFFF, "R3");
        rd(3'd1, 16'h0000, "R4");

        // R2 wrap
        sat_mode = 1'b0;
        pulse_cnt(4'b0010, 65535);
        rd(3'd1, 16'hFFFF, "R2");
        pulse_cnt(4'b0010, 1);
        rd(3'd1, 16'h0000, "R2");

        // status, write-1-to-clear
        pulse_stat(8'h05);
        rd(3'd4, 16'h0005, "R8");
        rd(3'd4, 16'h0005, "R9");
        wr(3'd4, 16'h0001);
        rd(3'd4, 16'h0004, "R9");
        access(1'b0, 1'b1, 3'd4, 16'h0004, 4'h0, 8'h04, 16'h0, "");
        rd(3'd4, 16'h0004, "R11");

        // status, read-to-clear
        clr_on_rd = 1'b1;
        wr(3'd4, 16'h00FF);
        rd(3'd4, 16'h0004, "R10");
        rd(3'd4, 16'h0000, "R10");
        pulse_stat(8'h80);
        access(1'b1, 1'b0, 3'd4, 16'h0, 4'h0, 8'h80, 16'h0080, "R11");
        rd(3'd4, 16'h0080, "R11");
        rd(3'd4, 16'h0000, "R10");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule